// File: doc/BRIEF.md
# Streaming Packet Loopback Controller

This block sits between two near-side slave ports and two far-side masters. The near-side ports are the read side of a receive buffer and the write side of a transmit buffer. In pass-through mode each far-side master is wired straight to its near-side slave, and the block adds no cycles. In loopback mode the far side is cut off. The block then becomes the master on both near-side ports: it pulls framed packets from the receive buffer and pushes them into the transmit buffer through a one-beat holding register.

Each beat carries a 128-bit word, a 4-bit count of unused bytes, an 8-bit channel tag, and three flags: start of packet, end of packet and error. Both slave ports have a ready-style status and a master-driven strobe.
- On the receive side, `near_rx_avail` means a beat can be read. The master pulses `near_rx_rd`, and the slave presents the beat one cycle later with `near_rx_valid` high.
- On the transmit side, `near_tx_space` acts as ready. A beat is accepted in every cycle in which `near_tx_wr` is high.
- While `near_tx_space` is low, the block holds its beat and issues no new read.

A request on `loop_req` takes effect only at a packet boundary, so no packet is split between the two modes.

Top module: `lpbk_loopback_ctl`

## Requirements
- R1: After synchronous reset (`rst` high) the block is in pass-through mode, the holding register is empty and neither packet tracker reports a packet in progress.
- R2: In pass-through mode the far receive master is wired to the near receive slave in the same cycle: `far_rx_avail`, `far_rx_valid` and all beat fields follow the `near_rx_*` values, and `near_rx_rd` equals `far_rx_rd`.
- R3: In pass-through mode the far transmit master is wired to the near transmit slave in the same cycle: `near_tx_wr` and the beat fields follow `far_tx_*`, and `far_tx_space` equals `near_tx_space`.
- R4: In loopback mode `far_rx_avail`, `far_rx_valid` and `far_tx_space` are held low. In this mode `far_rx_rd` and `far_tx_wr` have no effect on the near ports.
- R5: In loopback mode `near_rx_rd` is a single-cycle pulse. It is issued only after a cycle in which all of these hold:
  - `near_rx_avail` and `near_tx_space` are high;
  - no read is outstanding;
  - the holding register is empty or being written out in that cycle.
- R6: In loopback mode a beat returned with `near_rx_valid` is written to the transmit slave in the next cycle when `near_tx_space` is high. The write enable therefore rises two cycles after the read pulse.
- R7: While `near_tx_space` is low in loopback mode, `near_tx_wr` stays low, the held beat is kept, and no more than one beat is pending. The beat is written unchanged once space returns.
- R8: The mode changes only when all of the following hold:
  - no packet is in progress on the receive side (tracked from `near_rx_valid` beats) or on the transmit side (tracked from `near_tx_wr` beats);
  - no read is pending;
  - the holding register is empty.

  After `loop_req` falls, loopback finishes the current packet and starts no new one.
- R9: Loopback keeps beat order and every field (start, end, error, empty count, channel, data). This includes single-beat packets that carry both start and end.
- R10: Once the boundary condition of R8 holds, the new mode is in force from the cycle after the clock edge at which it was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loop_req | input | 1 | 1 requests loopback, 0 requests pass-through |
| near_rx_avail | input | 1 | Receive slave holds a readable beat |
| near_rx_rd | output | 1 | Read strobe to the receive slave |
| near_rx_valid | input | 1 | Receive slave presents a beat this cycle |
| near_rx_sop | input | 1 | Receive beat start of packet |
| near_rx_eop | input | 1 | Receive beat end of packet |
| near_rx_err | input | 1 | Receive beat error flag |
| near_rx_empty | input | 4 | Receive beat unused byte count |
| near_rx_ch | input | 8 | Receive beat channel tag |
| near_rx_data | input | 128 | Receive beat data |
| near_tx_space | input | 1 | Transmit slave can accept a beat |
| near_tx_wr | output | 1 | Write strobe to the transmit slave |
| near_tx_sop | output | 1 | Transmit beat start of packet |
| near_tx_eop | output | 1 | Transmit beat end of packet |
| near_tx_err | output | 1 | Transmit beat error flag |
| near_tx_empty | output | 4 | Transmit beat unused byte count |
| near_tx_ch | output | 8 | Transmit beat channel tag |
| near_tx_data | output | 128 | Transmit beat data |
| far_rx_avail | output | 1 | Readable beat status shown to the far reader |
| far_rx_rd | input | 1 | Read strobe from the far reader |
| far_rx_valid | output | 1 | Beat valid to the far reader |
| far_rx_sop | output | 1 | Far reader beat start of packet |
| far_rx_eop | output | 1 | Far reader beat end of packet |
| far_rx_err | output | 1 | Far reader beat error flag |
| far_rx_empty | output | 4 | Far reader beat unused byte count |
| far_rx_ch | output | 8 | Far reader beat channel tag |
| far_rx_data | output | 128 | Far reader beat data |
| far_tx_space | output | 1 | Space status shown to the far writer |
| far_tx_wr | input | 1 | Write strobe from the far writer |
| far_tx_sop | input | 1 | Far writer beat start of packet |
| far_tx_eop | input | 1 | Far writer beat end of packet |
| far_tx_err | input | 1 | Far writer beat error flag |
| far_tx_empty | input | 4 | Far writer beat unused byte count |
| far_tx_ch | input | 8 | Far writer beat channel tag |
| far_tx_data | input | 128 | Far writer beat data |

## Verification
The internal state here is the mode, two packet trackers, the outstanding-read flag and the holding register. A stale tracker shows within a few cycles: `far_tx_space` or `far_rx_avail` flips too early (mid-packet) or never flips. A wrong outstanding-read or hold flag shows as back-to-back read pulses, a beat lost or doubled at the transmit port, or a write appearing while space is low. A wrong capture of the holding register shows in the very next write, as a field that differs from the beat read. The directed scenarios place the mode request inside packets, stall the transmit side with a beat held, and compare every written beat and its timing against the expected sequence.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_LOOP = 1'b1
  } lpbk_mode_e;
endpackage

// File: rtl/lpbk_pkt_track.sv
module lpbk_pkt_track (
  input  logic clk,
  input  logic rst,
  input  logic xfer,
  input  logic sop,
  input  logic eop,
  output logic in_pkt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
    end else if (xfer) begin
      if (eop)      in_pkt <= 1'b0;
      else if (sop) in_pkt <= 1'b1;
    end
  end
endmodule

// File: rtl/lpbk_mode_ctl.sv
module lpbk_mode_ctl
  import lpbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loop_req,
  input  logic       rx_inpkt,
  input  logic       tx_inpkt,
  input  logic       busy,
  output lpbk_mode_e mode
);
  lpbk_mode_e want;
  logic       at_boundary;

  assign want        = loop_req ? MODE_LOOP : MODE_PASS;
  assign at_boundary = !rx_inpkt && !tx_inpkt && !busy;

  always_ff @(posedge clk) begin
    if (rst)              mode <= MODE_PASS;
    else if (at_boundary) mode <= want;
  end

  // R8
  rx_split_chk: assert property (@(posedge clk) disable iff (rst)
    rx_inpkt |=> (mode == $past(mode)));

  // R8
  tx_split_chk: assert property (@(posedge clk) disable iff (rst)
    tx_inpkt |=> (mode == $past(mode)));
endmodule

// File: rtl/lpbk_engine.sv
module lpbk_engine #(
  parameter int BEAT_W = 143
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              allow_start,
  input  logic              rx_inpkt,
  input  logic              rx_avail,
  input  logic              rx_valid,
  input  logic [BEAT_W-1:0] rx_beat,
  input  logic              tx_space,
  output logic              rd,
  output logic              tx_wr,
  output logic [BEAT_W-1:0] tx_beat,
  output logic              busy
);
  logic hold_vld;
  logic drain;
  logic issue;

  assign drain = active && hold_vld && tx_space;
  assign issue = active && (allow_start || rx_inpkt) && rx_avail && tx_space
                 && !rd && !rx_valid && (!hold_vld || drain);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd       <= 1'b0;
      hold_vld <= 1'b0;
      tx_beat  <= '0;
    end else begin
      rd <= issue;
      if (active && rx_valid) begin
        hold_vld <= 1'b1;
        tx_beat  <= rx_beat;
      end else if (drain) begin
        hold_vld <= 1'b0;
      end
    end
  end

  assign tx_wr = drain;
  assign busy  = hold_vld || rd;

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> !rd);

  // R5
  rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd |-> $past(rx_avail && tx_space && active));

  // R7
  hold_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rx_valid) |-> (!hold_vld || tx_space));
endmodule

// File: rtl/lpbk_loopback_ctl.sv
module lpbk_loopback_ctl
  import lpbk_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int EMPTY_W = 4,
  parameter int CH_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loop_req,
  input  logic               near_rx_avail,
  output logic               near_rx_rd,
  input  logic               near_rx_valid,
  input  logic               near_rx_sop,
  input  logic               near_rx_eop,
  input  logic               near_rx_err,
  input  logic [EMPTY_W-1:0] near_rx_empty,
  input  logic [CH_W-1:0]    near_rx_ch,
  input  logic [DATA_W-1:0]  near_rx_data,
  input  logic               near_tx_space,
  output logic               near_tx_wr,
  output logic               near_tx_sop,
  output logic               near_tx_eop,
  output logic               near_tx_err,
  output logic [EMPTY_W-1:0] near_tx_empty,
  output logic [CH_W-1:0]    near_tx_ch,
  output logic [DATA_W-1:0]  near_tx_data,
  output logic               far_rx_avail,
  input  logic               far_rx_rd,
  output logic               far_rx_valid,
  output logic               far_rx_sop,
  output logic               far_rx_eop,
  output logic               far_rx_err,
  output logic [EMPTY_W-1:0] far_rx_empty,
  output logic [CH_W-1:0]    far_rx_ch,
  output logic [DATA_W-1:0]  far_rx_data,
  output logic               far_tx_space,
  input  logic               far_tx_wr,
  input  logic               far_tx_sop,
  input  logic               far_tx_eop,
  input  logic               far_tx_err,
  input  logic [EMPTY_W-1:0] far_tx_empty,
  input  logic [CH_W-1:0]    far_tx_ch,
  input  logic [DATA_W-1:0]  far_tx_data
);
  localparam int BEAT_W = DATA_W + EMPTY_W + CH_W + 3;

  lpbk_mode_e        mode;
  logic              loop_on;
  logic              rx_inpkt, tx_inpkt;
  logic              eng_rd, eng_wr, eng_busy;
  logic [BEAT_W-1:0] rx_beat, far_in_beat, hold_beat;
  logic [BEAT_W-1:0] tx_beat, far_out_beat;

  assign loop_on     = (mode == MODE_LOOP);
  assign rx_beat     = {near_rx_sop, near_rx_eop, near_rx_err,
                        near_rx_empty, near_rx_ch, near_rx_data};
  assign far_in_beat = {far_tx_sop, far_tx_eop, far_tx_err,
                        far_tx_empty, far_tx_ch, far_tx_data};

  lpbk_engine #(.BEAT_W(BEAT_W)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .active      (loop_on),
    .allow_start (loop_req),
    .rx_inpkt    (rx_inpkt),
    .rx_avail    (near_rx_avail),
    .rx_valid    (near_rx_valid),
    .rx_beat     (rx_beat),
    .tx_space    (near_tx_space),
    .rd          (eng_rd),
    .tx_wr       (eng_wr),
    .tx_beat     (hold_beat),
    .busy        (eng_busy)
  );

  lpbk_pkt_track u_rx_track (
    .clk    (clk),
    .rst    (rst),
    .xfer   (near_rx_valid),
    .sop    (near_rx_sop),
    .eop    (near_rx_eop),
    .in_pkt (rx_inpkt)
  );

  lpbk_pkt_track u_tx_track (
    .clk    (clk),
    .rst    (rst),
    .xfer   (near_tx_wr),
    .sop    (near_tx_sop),
    .eop    (near_tx_eop),
    .in_pkt (tx_inpkt)
  );

  lpbk_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .loop_req (loop_req),
    .rx_inpkt (rx_inpkt),
    .tx_inpkt (tx_inpkt),
    .busy     (eng_busy || near_rx_rd || near_rx_valid),
    .mode     (mode)
  );

  always_comb begin
    if (loop_on) begin
      near_rx_rd   = eng_rd;
      near_tx_wr   = eng_wr;
      tx_beat      = hold_beat;
      far_rx_avail = 1'b0;
      far_rx_valid = 1'b0;
      far_out_beat = '0;
      far_tx_space = 1'b0;
    end else begin
      near_rx_rd   = far_rx_rd;
      near_tx_wr   = far_tx_wr;
      tx_beat      = far_in_beat;
      far_rx_avail = near_rx_avail;
      far_rx_valid = near_rx_valid;
      far_out_beat = rx_beat;
      far_tx_space = near_tx_space;
    end
  end

  assign {near_tx_sop, near_tx_eop, near_tx_err,
          near_tx_empty, near_tx_ch, near_tx_data} = tx_beat;
  assign {far_rx_sop, far_rx_eop, far_rx_err,
          far_rx_empty, far_rx_ch, far_rx_data} = far_out_beat;

  // R4
  far_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_on && !far_tx_wr && !far_rx_rd) |-> !far_rx_valid && !far_tx_space);

  // R7
  wr_space_chk: assert property (@(posedge clk) disable iff (rst)
    (loop_on && near_tx_wr) |-> near_tx_space);
endmodule

// File: tb/sim_lpbk_loopback_ctl.sv
`timescale 1ns/1ps
module sim_lpbk_loopback_ctl;
  localparam int BW = 143;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          loop_req = 1'b0;
  logic          near_rx_rd, near_tx_wr;
  logic          near_tx_space = 1'b1;
  logic          far_rx_rd = 1'b0, far_tx_wr = 1'b0;
  logic          far_rx_avail, far_rx_valid, far_tx_space;
  logic [BW-1:0] far_tx_v = '0;
  logic          n_rx_sop, n_rx_eop, n_rx_err;
  logic [3:0]    n_rx_empty;
  logic [7:0]    n_rx_ch;
  logic [127:0]  n_rx_data;
  logic          f_tx_sop, f_tx_eop, f_tx_err;
  logic [3:0]    f_tx_empty;
  logic [7:0]    f_tx_ch;
  logic [127:0]  f_tx_data;
  logic          t_sop, t_eop, t_err, r_sop, r_eop, r_err;
  logic [3:0]    t_empty, r_empty;
  logic [7:0]    t_ch, r_ch;
  logic [127:0]  t_data, r_data;
  logic [BW-1:0] tx_out, far_out;

  // receive slave model
  logic [BW-1:0] rxq [0:15];
  int            rx_n = 0;
  int            rx_i;
  logic          rx_valid_r;
  logic [BW-1:0] rx_beat_r;
  logic          near_rx_avail;

  assign near_rx_avail = (rx_i < rx_n);
  assign {n_rx_sop, n_rx_eop, n_rx_err, n_rx_empty, n_rx_ch, n_rx_data} = rx_beat_r;
  assign {f_tx_sop, f_tx_eop, f_tx_err, f_tx_empty, f_tx_ch, f_tx_data} = far_tx_v;
  assign tx_out  = {t_sop, t_eop, t_err, t_empty, t_ch, t_data};
  assign far_out = {r_sop, r_eop, r_err, r_empty, r_ch, r_data};

  always @(posedge clk) begin
    if (rst) begin
      rx_i       <= 0;
      rx_valid_r <= 1'b0;
      rx_beat_r  <= '0;
    end else if (near_rx_rd && rx_i < rx_n) begin
      rx_beat_r  <= rxq[rx_i];
      rx_valid_r <= 1'b1;
      rx_i       <= rx_i + 1;
    end else begin
      rx_valid_r <= 1'b0;
    end
  end

  // transmit sink and monitors
  logic [BW-1:0] txq [0:31];
  int tx_n = 0, rd_total = 0, cyc = 0, rd_twice = 0, far_leak = 0;
  int rd_cyc [0:63];
  int wr_cyc [0:63];
  logic prev_rd = 1'b0;
  logic watch_far = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (near_tx_wr && tx_n < 32) begin
        txq[tx_n]    <= tx_out;
        wr_cyc[tx_n] <= cyc;
        tx_n         <= tx_n + 1;
      end
      if (near_rx_rd && rd_total < 64) begin
        rd_cyc[rd_total] <= cyc;
        rd_total         <= rd_total + 1;
      end
      if (near_rx_rd && prev_rd) rd_twice <= rd_twice + 1;
      prev_rd <= near_rx_rd;
      if (watch_far && (far_rx_valid || far_rx_avail || far_tx_space))
        far_leak <= far_leak + 1;
    end
  end

  lpbk_loopback_ctl u0 (
    .clk(clk), .rst(rst), .loop_req(loop_req),
    .near_rx_avail(near_rx_avail), .near_rx_rd(near_rx_rd), .near_rx_valid(rx_valid_r),
    .near_rx_sop(n_rx_sop), .near_rx_eop(n_rx_eop), .near_rx_err(n_rx_err),
    .near_rx_empty(n_rx_empty), .near_rx_ch(n_rx_ch), .near_rx_data(n_rx_data),
    .near_tx_space(near_tx_space), .near_tx_wr(near_tx_wr),
    .near_tx_sop(t_sop), .near_tx_eop(t_eop), .near_tx_err(t_err),
    .near_tx_empty(t_empty), .near_tx_ch(t_ch), .near_tx_data(t_data),
    .far_rx_avail(far_rx_avail), .far_rx_rd(far_rx_rd), .far_rx_valid(far_rx_valid),
    .far_rx_sop(r_sop), .far_rx_eop(r_eop), .far_rx_err(r_err),
    .far_rx_empty(r_empty), .far_rx_ch(r_ch), .far_rx_data(r_data),
    .far_tx_space(far_tx_space), .far_tx_wr(far_tx_wr),
    .far_tx_sop(f_tx_sop), .far_tx_eop(f_tx_eop), .far_tx_err(f_tx_err),
    .far_tx_empty(f_tx_empty), .far_tx_ch(f_tx_ch), .far_tx_data(f_tx_data)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] mk(input bit s, input bit e, input bit r,
                                       input logic [3:0] emp, input logic [7:0] ch,
                                       input int seed);
    logic [31:0] w;
    w = 32'(seed) * 32'h9E3779B1 + 32'h1234;
    return {s, e, r, emp, ch, w, ~w, w ^ 32'hA5A5A5A5, w + 32'd7};
  endfunction

  task automatic push(input logic [BW-1:0] b);
    rxq[rx_n] = b;
    rx_n++;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    ticks(3);
    rst = 1'b0;
    ticks(1);
    // R1: pass-through wiring and idle strobes after reset
    check(near_rx_rd == 1'b0 && near_tx_wr == 1'b0, "R1 strobes idle",
          BW'({near_rx_rd, near_tx_wr}), '0);
    check(far_tx_space == 1'b1, "R1 pass mode space mirror", BW'(far_tx_space), BW'(1));
    check(far_rx_avail == 1'b0, "R1 nothing readable", BW'(far_rx_avail), '0);
  endtask

  task automatic t_pass_rx;
    logic [BW-1:0] b;
    b = mk(1, 1, 0, 4'd3, 8'h21, 5);
    push(b);
    #0.5;
    check(far_rx_avail == 1'b1, "R2 avail mirror", BW'(far_rx_avail), BW'(1));
    far_rx_rd = 1'b1;
    #0.5;
    check(near_rx_rd == 1'b1, "R2 read strobe passes", BW'(near_rx_rd), BW'(1));
    @(negedge clk);
    far_rx_rd = 1'b0;
    check(far_rx_valid == 1'b1 && far_out == b, "R2 beat to far reader", far_out, b);
    ticks(1);
    check(far_rx_valid == 1'b0, "R2 valid single cycle", BW'(far_rx_valid), '0);
  endtask

  task automatic t_pass_tx;
    logic [BW-1:0] b;
    int base;
    base = tx_n;
    b = mk(1, 1, 1, 4'd9, 8'h7E, 11);
    far_tx_v = b;
    far_tx_wr = 1'b1;
    #0.5;
    check(near_tx_wr == 1'b1 && tx_out == b, "R3 beat to transmit slave", tx_out, b);
    near_tx_space = 1'b0;
    #0.5;
    check(far_tx_space == 1'b0, "R3 space mirror low", BW'(far_tx_space), '0);
    near_tx_space = 1'b1;
    @(negedge clk);
    far_tx_wr = 1'b0;
    check(tx_n == base + 1, "R3 one beat written", BW'(tx_n - base), BW'(1));
  endtask

  task automatic t_enter_loop;
    far_tx_v = mk(1, 0, 0, 4'd0, 8'h01, 20);
    far_tx_wr = 1'b1;
    @(negedge clk);
    far_tx_wr = 1'b0;
    loop_req = 1'b1;
    ticks(4);
    // R8: packet open on transmit side, mode must stay pass-through
    check(far_tx_space == 1'b1, "R8 no switch mid-packet", BW'(far_tx_space), BW'(1));
    far_tx_v = mk(0, 1, 0, 4'd2, 8'h01, 21);
    far_tx_wr = 1'b1;
    @(negedge clk);
    far_tx_wr = 1'b0;
    check(far_tx_space == 1'b1, "R10 not yet switched", BW'(far_tx_space), BW'(1));
    ticks(1);
    check(far_tx_space == 1'b0, "R10 loopback in force", BW'(far_tx_space), '0);
  endtask

  task automatic t_loop_flow;
    logic [BW-1:0] exp [0:3];
    int wb, rb;
    wb = tx_n;
    rb = rd_total;
    watch_far = 1'b1;
    far_tx_v  = mk(1, 1, 1, 4'hF, 8'hFF, 99);
    far_tx_wr = 1'b1;
    far_rx_rd = 1'b1;
    exp[0] = mk(1, 0, 0, 4'd0, 8'h10, 31);
    exp[1] = mk(0, 0, 0, 4'd0, 8'h10, 32);
    exp[2] = mk(0, 1, 1, 4'd5, 8'h10, 33);
    exp[3] = mk(1, 1, 0, 4'd12, 8'hC3, 34);
    for (int k = 0; k < 4; k++) push(exp[k]);
    ticks(30);
    far_tx_wr = 1'b0;
    far_rx_rd = 1'b0;
    watch_far = 1'b0;
    check(tx_n - wb == 4, "R4 only looped beats written", BW'(tx_n - wb), BW'(4));
    for (int k = 0; k < 4; k++)
      check(txq[wb + k] == exp[k], "R9 beat order and fields", txq[wb + k], exp[k]);
    check(far_leak == 0, "R4 far side quiet", BW'(far_leak), '0);
    check(rd_twice == 0, "R5 read pulses single", BW'(rd_twice), '0);
    check(rd_total - rb == 4, "R5 no read without data", BW'(rd_total - rb), BW'(4));
    check(wr_cyc[wb] - rd_cyc[rb] == 2, "R6 read to write latency",
          BW'(wr_cyc[wb] - rd_cyc[rb]), BW'(2));
  endtask

  task automatic t_backpressure;
    logic [BW-1:0] exp [0:2];
    int wb, rb, guard;
    wb = tx_n;
    rb = rd_total;
    near_tx_space = 1'b0;
    exp[0] = mk(1, 0, 0, 4'd0, 8'h44, 41);
    exp[1] = mk(0, 0, 1, 4'd0, 8'h44, 42);
    exp[2] = mk(0, 1, 0, 4'd7, 8'h44, 43);
    for (int k = 0; k < 3; k++) push(exp[k]);
    ticks(8);
    check(rd_total == rb && tx_n == wb, "R7 no motion without space",
          BW'(rd_total - rb), '0);
    near_tx_space = 1'b1;
    guard = 0;
    while (tx_n == wb && guard < 20) begin
      ticks(1);
      guard++;
    end
    ticks(1);
    near_tx_space = 1'b0;
    ticks(8);
    check(tx_n - wb == 1, "R7 held beat not written", BW'(tx_n - wb), BW'(1));
    check(rd_total - rb == 2, "R7 one beat pending only", BW'(rd_total - rb), BW'(2));
    near_tx_space = 1'b1;
    ticks(20);
    check(tx_n - wb == 3, "R7 all beats after resume", BW'(tx_n - wb), BW'(3));
    for (int k = 0; k < 3; k++)
      check(txq[wb + k] == exp[k], "R7 beats unchanged", txq[wb + k], exp[k]);
  endtask

  task automatic t_exit_loop;
    logic [BW-1:0] a0, a1, bb;
    int wb, guard;
    wb = tx_n;
    a0 = mk(1, 0, 0, 4'd0, 8'h55, 51);
    a1 = mk(0, 1, 0, 4'd1, 8'h55, 52);
    bb = mk(1, 1, 0, 4'd4, 8'h66, 53);
    near_tx_space = 1'b0;
    push(a0);
    push(a1);
    push(bb);
    ticks(2);
    near_tx_space = 1'b1;
    guard = 0;
    while (tx_n == wb && guard < 20) begin
      ticks(1);
      guard++;
    end
    loop_req = 1'b0;
    ticks(20);
    check(tx_n - wb == 2, "R8 packet completed, none started", BW'(tx_n - wb), BW'(2));
    check(txq[wb + 1] == a1, "R8 tail beat delivered", txq[wb + 1], a1);
    check(far_rx_avail == 1'b1, "R10 pass-through restored", BW'(far_rx_avail), BW'(1));
    far_rx_rd = 1'b1;
    @(negedge clk);
    far_rx_rd = 1'b0;
    check(far_rx_valid == 1'b1 && far_out == bb, "R2 remaining packet to far reader",
          far_out, bb);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pass_rx();
    t_pass_tx();
    t_enter_loop();
    t_loop_flow();
    t_backpressure();
    t_exit_loop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule